// File: doc/BRIEF.md
# Ethernet Transmit Frame Engine

This block turns frame bytes held in transmit buffers into a MII-style transmit symbol stream. An upstream buffer reader presents one byte at a time. Each byte is tagged with whether it ends its buffer and whether that buffer is the final one of the frame. The engine pulls a byte only when it needs one. It sends a preamble and start delimiter, then the frame data, then zero padding up to the minimum size, and appends a CRC-32 when the frame asks for one. It holds transmit enable high for the whole frame.

When each buffer completes, the engine gives a completion pulse. When the frame ends, it gives a frame completion pulse together with the total length and an oversize flag. The oversize check uses a programmable limit, and an oversize frame is still sent in full. A stop request input keeps the engine from starting new frames. A frame already on the wire always finishes. Three interrupt pulses mirror the completion events through a mask.

Upstream must keep `in_valid` high for the rest of a frame once the frame has started. Underrun is not handled.

Top module: `eth_tx_engine`

## Requirements
- R1: Each frame starts with 7 bytes of 0x55 followed by one 0xD5 byte. `tx_en` is high from the first preamble symbol through the last symbol of the frame, and low in the cycle after.
- R2: With `TXD_W`=4, each byte is sent as two symbols, low nibble first, so bits leave least significant first. The data bytes appear on `txd` in the order they were taken from the buffers.
- R3: A buffer that is not the last of its frame gives one `buf_done` pulse without `frame_done`. The last buffer gives `buf_done` and `frame_done` in the same cycle, after the frame's final symbol.
- R4: When a frame has fewer than 60 data bytes, zero bytes are sent after the data until 60 bytes have followed the delimiter.
- R5: When `in_crc_en` is high on the first byte of a frame, four check bytes follow the data and pad. They carry the complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones) over data and pad, low-order byte first.
- R6: When `in_crc_en` is low on the first byte, nothing follows the data and pad.
- R7: At `frame_done`, `frame_len` equals the number of bytes sent after the delimiter, check bytes included. `frame_babble` is high exactly when `frame_len` > `max_len`, and the frame is never shortened.
- R8: While `gstop` is high and no frame is in flight, no frame starts, no byte is taken, and `stopped` is high.
- R9: When `gstop` rises during a frame, that frame completes and the next frame waits until `gstop` falls.
- R10: `irq_buf`, `irq_frame` and `irq_babble` pulse with `buf_done`, `frame_done`, and `frame_done` with `frame_babble` respectively, each only when its mask bit (0, 1, 2) in `irq_mask` is set.
- R11: After reset, `tx_en`, `in_ready` and all pulse outputs are low, and `in_ready` is only ever high while `tx_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| max_len | input | LEN_W | Oversize limit in bytes |
| irq_mask | input | 3 | Interrupt enables: bit0 buffer, bit1 frame, bit2 oversize |
| gstop | input | 1 | Stop request, honoured between frames |
| in_valid | input | 1 | A buffer byte is available |
| in_data | input | 8 | Buffer byte |
| in_buf_end | input | 1 | Byte is the final byte of its buffer |
| in_frame_last | input | 1 | Byte belongs to the final buffer of the frame |
| in_crc_en | input | 1 | Append check bytes (sampled at frame start) |
| in_ready | output | 1 | Byte taken this cycle |
| txd | output | TXD_W | Transmit symbol |
| tx_en | output | 1 | Transmit enable |
| buf_done | output | 1 | Buffer completion pulse |
| frame_done | output | 1 | Frame completion pulse |
| frame_babble | output | 1 | Oversize status, valid with frame_done |
| frame_len | output | LEN_W | Frame length status, valid with frame_done |
| stopped | output | 1 | Stop request in force and engine idle |
| irq_buf | output | 1 | Masked buffer interrupt pulse |
| irq_frame | output | 1 | Masked frame interrupt pulse |
| irq_babble | output | 1 | Masked oversize interrupt pulse |

## Verification
The hardest case to reach is a stop request that arrives while a frame is on the wire, with the following frame already waiting in the buffers. The engine must finish the first frame and then hold off the second. The bench loads two complete frames into its buffer model before it releases them. It raises `gstop` as soon as it sees `tx_en`, then waits well past the end of the first frame to confirm that no further symbols or bytes move. It then drops `gstop` and checks the second frame byte for byte at its offset in the captured stream.

// File: rtl/eth_tx_engine.sv
module eth_tx_engine #(
  parameter int TXD_W   = 4,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] max_len,
  input  logic [2:0]       irq_mask,
  input  logic             gstop,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_buf_end,
  input  logic             in_frame_last,
  input  logic             in_crc_en,
  output logic             in_ready,
  output logic [TXD_W-1:0] txd,
  output logic             tx_en,
  output logic             buf_done,
  output logic             frame_done,
  output logic             frame_babble,
  output logic [LEN_W-1:0] frame_len,
  output logic             stopped,
  output logic             irq_buf,
  output logic             irq_frame,
  output logic             irq_babble
);

  localparam int STEPS = 8 / TXD_W;
  localparam int NIB_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CNT_W = (PRE_LEN + 2 > 4) ? $clog2(PRE_LEN + 2) : 2;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_PAD, S_FCS} st_t;

  st_t              state;
  logic [NIB_W-1:0] nib;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       byte_q;
  logic [31:0]      crc_q, fcs_q;
  logic [LEN_W-1:0] len_q;
  logic             crc_en_q, last_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? 32'hEDB88320 : 32'h0);
    return r;
  endfunction

  logic             step_last, take, finish, need_pad;
  logic [LEN_W-1:0] tot_len;

  assign tx_en     = (state != S_IDLE);
  assign step_last = (nib == NIB_W'(STEPS - 1));
  assign txd       = tx_en ? byte_q[nib*TXD_W +: TXD_W] : '0;
  assign need_pad  = (len_q < LEN_W'(MIN_LEN));
  assign tot_len   = len_q + (crc_en_q ? LEN_W'(4) : LEN_W'(0));
  assign stopped   = gstop && (state == S_IDLE);
  assign take      = step_last && ((state == S_PRE && cnt == CNT_W'(PRE_LEN + 1)) ||
                                   (state == S_DATA && !last_q));
  assign finish    = step_last && ((state == S_FCS && cnt == CNT_W'(3)) ||
                     (((state == S_DATA && last_q) || state == S_PAD) && !need_pad && !crc_en_q));
  assign in_ready  = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      nib      <= '0;
      cnt      <= '0;
      byte_q   <= '0;
      crc_q    <= '1;
      fcs_q    <= '0;
      len_q    <= '0;
      crc_en_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      if (tx_en) nib <= step_last ? '0 : nib + 1'b1;
      if (take) begin
        state  <= S_DATA;
        byte_q <= in_data;
        crc_q  <= crc_byte(crc_q, in_data);
        len_q  <= len_q + 1'b1;
        last_q <= in_buf_end && in_frame_last;
      end else begin
        case (state)
          S_IDLE:
            if (in_valid && !gstop) begin
              state    <= S_PRE;
              nib      <= '0;
              byte_q   <= 8'h55;
              cnt      <= CNT_W'(1);
              crc_q    <= '1;
              len_q    <= '0;
              crc_en_q <= in_crc_en;
              last_q   <= 1'b0;
            end
          S_PRE:
            if (step_last) begin
              byte_q <= (cnt == CNT_W'(PRE_LEN)) ? 8'hD5 : 8'h55;
              cnt    <= cnt + 1'b1;
            end
          S_DATA, S_PAD:
            if (step_last) begin
              if (need_pad) begin
                state  <= S_PAD;
                byte_q <= 8'h00;
                crc_q  <= crc_byte(crc_q, 8'h00);
                len_q  <= len_q + 1'b1;
              end else if (crc_en_q) begin
                state  <= S_FCS;
                byte_q <= ~crc_q[7:0];
                fcs_q  <= ~crc_q;
                cnt    <= '0;
              end else begin
                state <= S_IDLE;
              end
            end
          S_FCS:
            if (step_last) begin
              if (cnt == CNT_W'(3)) state <= S_IDLE;
              else begin
                byte_q <= fcs_q[15:8];
                fcs_q  <= fcs_q >> 8;
                cnt    <= cnt + 1'b1;
              end
            end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_done     <= 1'b0;
      frame_done   <= 1'b0;
      frame_babble <= 1'b0;
      frame_len    <= '0;
      irq_buf      <= 1'b0;
      irq_frame    <= 1'b0;
      irq_babble   <= 1'b0;
    end else begin
      buf_done   <= finish || (take && in_buf_end && !in_frame_last);
      frame_done <= finish;
      irq_buf    <= irq_mask[0] && (finish || (take && in_buf_end && !in_frame_last));
      irq_frame  <= irq_mask[1] && finish;
      irq_babble <= irq_mask[2] && finish && (tot_len > max_len);
      if (finish) begin
        frame_len    <= tot_len;
        frame_babble <= (tot_len > max_len);
      end else begin
        frame_babble <= 1'b0;
      end
    end
  end

  p_ready_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en);
  p_txen_low_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !tx_en);
  p_frame_with_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> buf_done);
  p_min_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_len >= LEN_W'(MIN_LEN));
  p_babble_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_babble |-> frame_done);
  p_hold_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gstop && !tx_en) |=> !tx_en);
  p_stopped_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !tx_en && !in_ready);
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |-> frame_done);

endmodule

// File: tb/eth_tx_engine_tb_top.sv
`timescale 1ns/1ps
module eth_tx_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [15:0] max_len = 16'd1518;
  logic [2:0] irq_mask = 3'b111;
  logic gstop = 1'b0, crc_sel = 1'b1;
  logic in_ready, tx_en, buf_done, frame_done, frame_babble, stopped;
  logic irq_buf, irq_frame, irq_babble;
  logic [3:0] txd;
  logic [15:0] frame_len;

  logic [7:0] mem_d [0:511];
  logic       mem_e [0:511];
  logic       mem_l [0:511];
  int mem_n = 0, ptr = 0;
  logic clr = 1'b0;
  logic in_valid, in_buf_end, in_frame_last;
  logic [7:0] in_data;
  assign in_valid      = ptr < mem_n;
  assign in_data       = mem_d[ptr[8:0]];
  assign in_buf_end    = mem_e[ptr[8:0]];
  assign in_frame_last = mem_l[ptr[8:0]];

  eth_tx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .max_len(max_len), .irq_mask(irq_mask), .gstop(gstop),
    .in_valid(in_valid), .in_data(in_data), .in_buf_end(in_buf_end),
    .in_frame_last(in_frame_last), .in_crc_en(crc_sel), .in_ready(in_ready),
    .txd(txd), .tx_en(tx_en), .buf_done(buf_done), .frame_done(frame_done),
    .frame_babble(frame_babble), .frame_len(frame_len), .stopped(stopped),
    .irq_buf(irq_buf), .irq_frame(irq_frame), .irq_babble(irq_babble));

  logic [7:0] rx_b [0:511];
  logic [3:0] lo;
  logic ph, last_bab;
  int rx_n, tx_cyc, fd_cnt, bd_cnt, bd_mid, ib_cnt, if_cnt, iba_cnt, last_len;

  always @(posedge clk) begin
    if (clr) ptr <= 0;
    else if (in_ready && in_valid) ptr <= ptr + 1;
  end

  always @(posedge clk) begin
    if (clr) begin
      rx_n <= 0; tx_cyc <= 0; fd_cnt <= 0; bd_cnt <= 0; bd_mid <= 0; ph <= 1'b0;
      ib_cnt <= 0; if_cnt <= 0; iba_cnt <= 0; last_len <= 0; last_bab <= 1'b0; lo <= '0;
    end else begin
      if (tx_en) begin
        tx_cyc <= tx_cyc + 1;
        if (!ph) lo <= txd;
        else begin rx_b[rx_n[8:0]] <= {txd, lo}; rx_n <= rx_n + 1; end
        ph <= ~ph;
      end
      if (frame_done) begin fd_cnt <= fd_cnt + 1; last_len <= frame_len; last_bab <= frame_babble; end
      if (buf_done) bd_cnt <= bd_cnt + 1;
      if (buf_done && !frame_done) bd_mid <= bd_mid + 1;
      if (irq_buf) ib_cnt <= ib_cnt + 1;
      if (irq_frame) if_cnt <= if_cnt + 1;
      if (irq_babble) iba_cnt <= iba_cnt + 1;
    end
  end

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  logic [7:0] exp_d [0:511];
  int exp_n = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int ex);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, ex);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_test();
    @(negedge clk);
    mem_n = 0; exp_n = 0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic add_buf(input int n, input int seed, input bit last);
    for (int i = 0; i < n; i++) begin
      mem_d[mem_n] = 8'(seed + i * 7);
      mem_e[mem_n] = (i == n - 1);
      mem_l[mem_n] = last;
      exp_d[exp_n] = 8'(seed + i * 7);
      exp_n++;
      mem_n++;
    end
  endtask

  task automatic pad_exp(input int start);
    while (exp_n - start < 60) begin exp_d[exp_n] = 8'h00; exp_n++; end
  endtask

  task automatic wait_frames(input int k);
    int t = 0;
    while (fd_cnt < k && t < 5000) begin @(negedge clk); t++; end
    chk(fd_cnt >= k, "R3", "frame_done count", fd_cnt, k);
    tick(2);
  endtask

  function automatic logic [31:0] ref_crc(input int eo, input int n);
    logic [31:0] c, r;
    logic fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ exp_d[eo + i][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    for (int b = 0; b < 32; b++) r[b] = c[31 - b];
    return ~r;
  endfunction

  task automatic verify(input int rxo, input int eo, input int pl, input bit fcs, input string rq);
    int bad;
    logic [31:0] f;
    bad = -1;
    for (int i = 0; i < 8; i++)
      if (bad < 0 && rx_b[rxo + i] != ((i == 7) ? 8'hD5 : 8'h55)) bad = i;
    chk(bad < 0, "R1", "preamble/delimiter byte index", bad, -1);
    bad = -1;
    for (int i = 0; i < pl; i++)
      if (bad < 0 && rx_b[rxo + 8 + i] != exp_d[eo + i]) bad = i;
    chk(bad < 0, rq, "R2 payload first bad byte",
        (bad < 0) ? 0 : int'(rx_b[rxo + 8 + bad]), (bad < 0) ? 0 : int'(exp_d[eo + bad]));
    if (fcs) begin
      f = ref_crc(eo, pl);
      for (int k = 0; k < 4; k++)
        chk(rx_b[rxo + 8 + pl + k] == f[8*k +: 8], "R5", "check byte",
            int'(rx_b[rxo + 8 + pl + k]), int'(f[8*k +: 8]));
    end
  endtask

  task automatic t_reset();
    chk(!tx_en && !in_ready, "R11", "tx_en/in_ready after reset", {tx_en, in_ready}, 0);
    chk(!frame_done && !buf_done && !irq_buf, "R11", "pulses after reset", {frame_done, buf_done, irq_buf}, 0);
    chk(!stopped, "R8", "stopped without request", stopped, 0);
  endtask

  task automatic t_full();
    begin_test(); crc_sel = 1'b1; max_len = 16'd1518;
    add_buf(64, 3, 1'b1);
    wait_frames(1);
    verify(0, 0, 64, 1'b1, "R2");
    chk(rx_n == 76, "R1", "bytes on wire", rx_n, 76);
    chk(tx_cyc == 152, "R1", "tx_en high cycles", tx_cyc, 152);
    chk(last_len == 68, "R7", "frame_len", last_len, 68);
    chk(!last_bab, "R7", "babble below limit", last_bab, 0);
    chk(bd_cnt == 1 && bd_mid == 0, "R3", "single buffer done", bd_cnt, 1);
  endtask

  task automatic t_short();
    begin_test(); crc_sel = 1'b1; max_len = 16'd64;
    add_buf(10, 40, 1'b1); pad_exp(0);
    wait_frames(1);
    verify(0, 0, 60, 1'b1, "R4");
    chk(rx_n == 72, "R4", "padded bytes on wire", rx_n, 72);
    chk(last_len == 64, "R4", "padded frame_len", last_len, 64);
    chk(!last_bab, "R7", "babble at limit equal", last_bab, 0);
  endtask

  task automatic t_multi();
    begin_test(); crc_sel = 1'b1; max_len = 16'd1518;
    add_buf(20, 1, 1'b0); add_buf(15, 90, 1'b0); add_buf(30, 200, 1'b1);
    wait_frames(1);
    verify(0, 0, 65, 1'b1, "R2");
    chk(bd_cnt == 3, "R3", "buffer done pulses", bd_cnt, 3);
    chk(bd_mid == 2, "R3", "buffer done without frame done", bd_mid, 2);
    chk(fd_cnt == 1, "R3", "frame done pulses", fd_cnt, 1);
  endtask

  task automatic t_nocrc();
    begin_test(); crc_sel = 1'b0; max_len = 16'd1518;
    add_buf(70, 17, 1'b1);
    wait_frames(1);
    verify(0, 0, 70, 1'b0, "R6");
    chk(rx_n == 78, "R6", "bytes without check", rx_n, 78);
    chk(last_len == 70, "R6", "frame_len without check", last_len, 70);
    crc_sel = 1'b1;
  endtask

  task automatic t_babble();
    begin_test(); crc_sel = 1'b1; max_len = 16'd50;
    add_buf(70, 33, 1'b1);
    wait_frames(1);
    verify(0, 0, 70, 1'b1, "R7");
    chk(rx_n == 82, "R7", "oversize not truncated", rx_n, 82);
    chk(last_bab, "R7", "babble flag", last_bab, 1);
    chk(iba_cnt == 1, "R10", "babble irq enabled", iba_cnt, 1);
    max_len = 16'd1518;
  endtask

  task automatic t_mask();
    begin_test(); irq_mask = 3'b001; max_len = 16'd10;
    add_buf(20, 7, 1'b1);
    wait_frames(1);
    chk(ib_cnt == 1, "R10", "buf irq enabled", ib_cnt, 1);
    chk(if_cnt == 0, "R10", "frame irq masked", if_cnt, 0);
    chk(iba_cnt == 0, "R10", "babble irq masked", iba_cnt, 0);
    begin_test(); irq_mask = 3'b110;
    add_buf(20, 8, 1'b1);
    wait_frames(1);
    chk(ib_cnt == 0, "R10", "buf irq masked", ib_cnt, 0);
    chk(if_cnt == 1 && iba_cnt == 1, "R10", "frame+babble irq", if_cnt + iba_cnt, 2);
    irq_mask = 3'b111; max_len = 16'd1518;
  endtask

  task automatic t_stop_idle();
    begin_test(); gstop = 1'b1;
    add_buf(20, 11, 1'b1); pad_exp(0);
    tick(60);
    chk(tx_cyc == 0, "R8", "tx_en cycles while stopped", tx_cyc, 0);
    chk(stopped, "R8", "stopped flag", stopped, 1);
    chk(ptr == 0, "R8", "bytes taken while stopped", ptr, 0);
    gstop = 1'b0;
    wait_frames(1);
    verify(0, 0, 60, 1'b1, "R8");
  endtask

  task automatic t_stop_mid();
    int t;
    begin_test();
    add_buf(20, 5, 1'b1); pad_exp(0);
    add_buf(20, 9, 1'b1); pad_exp(60);
    t = 0;
    while (!tx_en && t < 100) begin @(negedge clk); t++; end
    gstop = 1'b1;
    wait_frames(1);
    tick(100);
    chk(fd_cnt == 1, "R9", "frames while stop held", fd_cnt, 1);
    chk(rx_n == 72, "R9", "bytes after first frame", rx_n, 72);
    chk(stopped, "R9", "stopped after frame", stopped, 1);
    verify(0, 0, 60, 1'b1, "R9");
    gstop = 1'b0;
    wait_frames(2);
    verify(72, 60, 60, 1'b1, "R9");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_full();
    t_short();
    t_multi();
    t_nocrc();
    t_babble();
    t_mask();
    t_stop_idle();
    t_stop_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule